// File: doc/BRIEF.md
# Dual-Channel DAC Sample Source Selector

This block sits in front of a serial DAC transmitter and hands it one 16-bit sample for each of two channels per transfer. Each channel independently chooses where its sample comes from: its half of a 32-bit word arriving on a valid/ready memory stream, its own 16-bit loopback input, or a free-running internal ramp. A sample pair is issued only when the transmitter can take it and every source the pair depends on has valid data. The pair is then presented on registered outputs, one cycle after it is accepted.

For multi-converter systems the block can hold itself idle until a start condition occurs. A one-cycle arm request puts the block in a waiting state. In that state it consumes nothing and drives zeros. The wait ends when the external sync input is high and the secondary stream valid is also high. The armed state then clears on its own, and a one-cycle start pulse is sent to a peer instance so that several instances leave the wait together. A build parameter removes the sync mechanism entirely. The reset `rst_n` is asynchronous and active low, and its release is expected to be synchronous to `clk`.

Top module: `dac_src_select`

## Requirements
- R1: Select code 0x2 feeds a channel from the stream word: channel 0 takes `stream_word[15:0]` and channel 1 takes `stream_word[31:16]`. `chan_sel[3:0]` is the code for channel 0 and `chan_sel[7:4]` is the code for channel 1.
- R2: Select code 0x8 feeds channel 0 from `loop_a` and channel 1 from `loop_b`. A pair is not issued while a channel set to loopback has its loopback valid low.
- R3: Select code 0xB feeds a channel from the ramp. The ramp counter starts at 0 after reset and advances by 1 for every issued pair, whatever the codes are. It wraps from 0xFFFF to 0x0000, and both channels see the same value in the same pair.
- R4: Every other code, including the reset default 0x0, behaves exactly like code 0x2.
- R5: A pair is issued on a clock edge only when `tx_ready` is high, the block is not armed, the stream is valid (if any channel uses it) and the needed loopback valids are high. The issued pair appears on `ch0_data`/`ch1_data` with `sample_valid` high for the single cycle after that edge. Otherwise `sample_valid` is low and the data hold.
- R6: `stream_ready` is high exactly when `tx_ready` is high, the block is not armed, at least one channel uses the stream, and every loopback valid needed by the current codes is high.
- R7: A high `sync_arm_set` sets the armed state, which is visible on `sync_armed` after the edge. While armed, `stream_ready` is low, no pair is issued, and from the following edge on both data outputs are zero.
- R8: While armed, an edge with `sync_in` and `stream2_valid` both high clears the armed state. In the same edge `peer_start` goes high for exactly one cycle. With either of them low the block stays armed.
- R9: With `EXT_SYNC_EN` = 0, `sync_arm_set` has no effect: `sync_armed` stays 0 and sample flow continues.
- R10: During reset, `sample_valid`, `ch0_data`, `ch1_data`, `sync_armed` and `peer_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chan_sel | input | 8 | Source codes: [3:0] channel 0, [7:4] channel 1 |
| stream_word | input | 32 | Stream word: [15:0] channel 0, [31:16] channel 1 |
| stream_valid | input | 1 | Stream word valid |
| stream_ready | output | 1 | Stream word accepted when high together with valid |
| loop_a | input | 16 | Loopback sample for channel 0 |
| loop_a_valid | input | 1 | Loopback valid for channel 0 |
| loop_b | input | 16 | Loopback sample for channel 1 |
| loop_b_valid | input | 1 | Loopback valid for channel 1 |
| stream2_valid | input | 1 | Secondary stream valid that gates the sync start |
| sync_arm_set | input | 1 | One-cycle request to arm the sync wait |
| sync_in | input | 1 | External sync from a peer or a system source |
| sync_armed | output | 1 | Armed state, clears itself on start |
| peer_start | output | 1 | One-cycle start pulse to a peer instance |
| tx_ready | input | 1 | Transmitter can accept a new sample pair |
| sample_valid | output | 1 | A new pair is on the data outputs |
| ch0_data | output | 16 | Channel 0 sample |
| ch1_data | output | 16 | Channel 1 sample |

## Verification
The ramp wrap is the hardest case to reach from the ports. The counter advances only with issued pairs, so reaching 0xFFFF takes tens of thousands of transfers. The bench keeps its own count of issued pairs from the start. It then sets both channels to the ramp with the transmitter always ready and compares every sample until the value passes 0xFFFF back to 0x0000. The armed wait is walked step by step: arming, stalled ready, zeroed data, a sync pulse with the secondary valid held low, and finally the release. Alongside, a second instance built without sync must ignore the same arm request.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;

  localparam int unsigned SEL_W = 4;

  localparam logic [SEL_W-1:0] CODE_STREAM = 4'h2;
  localparam logic [SEL_W-1:0] CODE_LOOP   = 4'h8;
  localparam logic [SEL_W-1:0] CODE_RAMP   = 4'hB;

  typedef enum logic [1:0] {
    SRC_STREAM = 2'd0,
    SRC_LOOP   = 2'd1,
    SRC_RAMP   = 2'd2
  } src_e;

  function automatic src_e decode_sel(input logic [SEL_W-1:0] code);
    src_e s;
    case (code)
      CODE_LOOP: s = SRC_LOOP;
      CODE_RAMP: s = SRC_RAMP;
      default:   s = SRC_STREAM;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dac_src_decode.sv
module dac_src_decode
  import dac_src_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH*SEL_W-1:0] sel,
  output logic [NUM_CH-1:0]       use_stream,
  output logic [NUM_CH-1:0]       use_loop,
  output logic [NUM_CH-1:0]       use_ramp
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    src_e src;
    always_comb begin
      src           = decode_sel(sel[i*SEL_W +: SEL_W]);
      use_stream[i] = (src == SRC_STREAM);
      use_loop[i]   = (src == SRC_LOOP);
      use_ramp[i]   = (src == SRC_RAMP);
    end
  end

endmodule

// File: rtl/dac_ramp_gen.sv
module dac_ramp_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] ramp_q
);

  logic [W-1:0] ramp_d;

  always_comb begin
    ramp_d = ramp_q;
    if (step) ramp_d = ramp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ramp_q <= '0;
    else        ramp_q <= ramp_d;
  end

endmodule

// File: rtl/dac_sync_ctrl.sv
module dac_sync_ctrl #(
  parameter bit EXT_SYNC_EN = 1'b1,
  parameter bit SEC_GATE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic sync_in,
  input  logic sec_valid,
  output logic armed_q,
  output logic start_q
);

  logic arm_req;
  logic gate_ok;
  logic start_evt;
  logic armed_d;
  logic start_d;

  always_comb begin
    arm_req   = EXT_SYNC_EN ? arm_set : 1'b0;
    gate_ok   = SEC_GATE_EN ? sec_valid : 1'b1;
    start_evt = armed_q & sync_in & gate_ok;
    armed_d   = armed_q;
    if (start_evt)    armed_d = 1'b0;
    else if (arm_req) armed_d = 1'b1;
    start_d   = start_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      start_q <= start_d;
    end
  end

endmodule

// File: rtl/dac_chan_out.sv
module dac_chan_out #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic         use_loop,
  input  logic         use_ramp,
  input  logic [W-1:0] stream_half,
  input  logic [W-1:0] loop_data,
  input  logic [W-1:0] ramp_val,
  output logic [W-1:0] data_q
);

  logic [W-1:0] pick;
  logic [W-1:0] data_d;

  always_comb begin
    if (use_ramp)      pick = ramp_val;
    else if (use_loop) pick = loop_data;
    else               pick = stream_half;
    data_d = data_q;
    if (clear)     data_d = '0;
    else if (load) data_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

endmodule

// File: rtl/dac_src_select.sv
module dac_src_select
  import dac_src_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter bit          EXT_SYNC_EN = 1'b1,
  parameter bit          SEC_GATE_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*SEL_W-1:0] chan_sel,
  input  logic [2*W-1:0]     stream_word,
  input  logic               stream_valid,
  output logic               stream_ready,
  input  logic [W-1:0]       loop_a,
  input  logic               loop_a_valid,
  input  logic [W-1:0]       loop_b,
  input  logic               loop_b_valid,
  input  logic               stream2_valid,
  input  logic               sync_arm_set,
  input  logic               sync_in,
  output logic               sync_armed,
  output logic               peer_start,
  input  logic               tx_ready,
  output logic               sample_valid,
  output logic [W-1:0]       ch0_data,
  output logic [W-1:0]       ch1_data
);

  localparam int unsigned NUM_CH = 2;

  logic [NUM_CH-1:0] use_stream;
  logic [NUM_CH-1:0] use_loop;
  logic [NUM_CH-1:0] use_ramp;
  logic [NUM_CH-1:0] loop_v;
  logic [W-1:0]      loop_d [NUM_CH];
  logic [W-1:0]      ch_q   [NUM_CH];
  logic [W-1:0]      ramp_q;
  logic              armed;
  logic              need_stream;
  logic              loop_ok;
  logic              issue;
  logic              valid_d;

  dac_src_decode #(.NUM_CH(NUM_CH)) u_decode (
    .sel        (chan_sel),
    .use_stream (use_stream),
    .use_loop   (use_loop),
    .use_ramp   (use_ramp)
  );

  dac_sync_ctrl #(.EXT_SYNC_EN(EXT_SYNC_EN), .SEC_GATE_EN(SEC_GATE_EN)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_set   (sync_arm_set),
    .sync_in   (sync_in),
    .sec_valid (stream2_valid),
    .armed_q   (armed),
    .start_q   (peer_start)
  );

  dac_ramp_gen #(.W(W)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (issue),
    .ramp_q (ramp_q)
  );

  always_comb begin
    loop_v      = {loop_b_valid, loop_a_valid};
    loop_d[0]   = loop_a;
    loop_d[1]   = loop_b;
    need_stream = |use_stream;
    loop_ok     = &(~use_loop | loop_v);
    stream_ready = tx_ready & ~armed & need_stream & loop_ok;
    issue        = tx_ready & ~armed & loop_ok & (~need_stream | stream_valid);
    valid_d      = issue;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_out
    dac_chan_out #(.W(W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (issue),
      .clear       (armed),
      .use_loop    (use_loop[i]),
      .use_ramp    (use_ramp[i]),
      .stream_half (stream_word[i*W +: W]),
      .loop_data   (loop_d[i]),
      .ramp_val    (ramp_q),
      .data_q      (ch_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_valid <= 1'b0;
    else        sample_valid <= valid_d;
  end

  assign sync_armed = armed;
  assign ch0_data   = ch_q[0];
  assign ch1_data   = ch_q[1];

endmodule

// File: rtl/dac_src_select_chk.sv
module dac_src_select_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_ready,
  input logic         stream_ready,
  input logic         sync_arm_set,
  input logic         sync_armed,
  input logic         peer_start,
  input logic         sample_valid,
  input logic [W-1:0] ch0_data,
  input logic [W-1:0] ch1_data
);

  assert_ready_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_armed |-> !stream_ready);

  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_armed) |-> (!sample_valid && ch0_data == '0 && ch1_data == '0));

  assert_arm_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_armed) |-> $past(sync_arm_set));

  assert_start_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_armed) |-> peer_start);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    peer_start |=> !peer_start);

  assert_issue_needs_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(tx_ready));

endmodule

bind dac_src_select dac_src_select_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_ready     (tx_ready),
  .stream_ready (stream_ready),
  .sync_arm_set (sync_arm_set),
  .sync_armed   (sync_armed),
  .peer_start   (peer_start),
  .sample_valid (sample_valid),
  .ch0_data     (ch0_data),
  .ch1_data     (ch1_data)
);

// File: tb/test_dac_src_select.sv
module test_dac_src_select;

  logic        clk;
  logic        rst_n;
  logic [7:0]  chan_sel;
  logic [31:0] stream_word;
  logic        stream_valid;
  logic        stream_ready;
  logic [15:0] loop_a, loop_b;
  logic        loop_a_valid, loop_b_valid;
  logic        stream2_valid, sync_arm_set, sync_in;
  logic        sync_armed, peer_start, tx_ready, sample_valid;
  logic [15:0] ch0_data, ch1_data;
  logic        ns_ready, ns_armed, ns_peer, ns_valid;
  logic [15:0] ns_ch0, ns_ch1;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] model;

  dac_src_select i_dac_src_select (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .stream_word(stream_word),
    .stream_valid(stream_valid), .stream_ready(stream_ready),
    .loop_a(loop_a), .loop_a_valid(loop_a_valid), .loop_b(loop_b), .loop_b_valid(loop_b_valid),
    .stream2_valid(stream2_valid), .sync_arm_set(sync_arm_set), .sync_in(sync_in),
    .sync_armed(sync_armed), .peer_start(peer_start), .tx_ready(tx_ready),
    .sample_valid(sample_valid), .ch0_data(ch0_data), .ch1_data(ch1_data)
  );

  dac_src_select #(.EXT_SYNC_EN(1'b0)) i_dac_src_select_nosync (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .stream_word(stream_word),
    .stream_valid(stream_valid), .stream_ready(ns_ready),
    .loop_a(loop_a), .loop_a_valid(loop_a_valid), .loop_b(loop_b), .loop_b_valid(loop_b_valid),
    .stream2_valid(stream2_valid), .sync_arm_set(sync_arm_set), .sync_in(sync_in),
    .sync_armed(ns_armed), .peer_start(ns_peer), .tx_ready(tx_ready),
    .sample_valid(ns_valid), .ch0_data(ns_ch0), .ch1_data(ns_ch1)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  sel;
    logic [31:0] word;
    logic [15:0] la;
    logic        lav;
    logic [15:0] lb;
    logic        lbv;
    logic        tx;
    logic        sv;
    logic        rdy;
    logic        v;
    logic [15:0] e0;
    logic [15:0] e1;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{8'h22, 32'hBEEF1234, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h1234, 16'hBEEF}, // R1
    '{8'h22, 32'h11112222, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5 tx low
    '{8'h22, 32'h33334444, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R5 stream idle
    '{8'h88, 32'h00000000, 16'h1111, 1'b1, 16'h2222, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h1111, 16'h2222}, // R2
    '{8'h88, 32'h00000000, 16'h5A5A, 1'b1, 16'hA5A5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R2 b invalid
    '{8'h28, 32'hAAAA5555, 16'h0F0F, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0F0F, 16'hAAAA}, // R1 R2 mixed
    '{8'h28, 32'hAAAA5555, 16'h0F0F, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R6
    '{8'h00, 32'h00C37E01, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h7E01, 16'h00C3}, // R4 code 0
    '{8'hF5, 32'h99996666, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h6666, 16'h9999}, // R4 odd codes
    '{8'hB2, 32'h12345678, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h5678, 16'h0005}  // R3 ch1 ramp
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; chan_sel = 8'h00; stream_word = '0; stream_valid = 1'b0;
    loop_a = '0; loop_b = '0; loop_a_valid = 1'b0; loop_b_valid = 1'b0;
    stream2_valid = 1'b0; sync_arm_set = 1'b0; sync_in = 1'b0; tx_ready = 1'b0;
    model = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R10", "valid", {31'b0, sample_valid}, 32'd0);
    chk("R10", "ch0", {16'b0, ch0_data}, 32'd0);
    chk("R10", "ch1", {16'b0, ch1_data}, 32'd0);
    chk("R10", "armed", {31'b0, sync_armed}, 32'd0);
    chk("R10", "peer", {31'b0, peer_start}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      chan_sel = TBL[k].sel; stream_word = TBL[k].word;
      loop_a = TBL[k].la; loop_a_valid = TBL[k].lav;
      loop_b = TBL[k].lb; loop_b_valid = TBL[k].lbv;
      tx_ready = TBL[k].tx; stream_valid = TBL[k].sv;
      #1;
      chk("R6", $sformatf("ready row %0d", k), {31'b0, stream_ready}, {31'b0, TBL[k].rdy});
      @(negedge clk);
      chk("R5", $sformatf("valid row %0d", k), {31'b0, sample_valid}, {31'b0, TBL[k].v});
      if (TBL[k].v) begin
        chk("R1 R2 R3 R4", $sformatf("ch0 row %0d", k), {16'b0, ch0_data}, {16'b0, TBL[k].e0});
        chk("R1 R2 R3 R4", $sformatf("ch1 row %0d", k), {16'b0, ch1_data}, {16'b0, TBL[k].e1});
        model = model + 16'h1;
      end
    end

    // R3: both channels on the ramp, transmitter always ready, through the wrap
    begin
      int bad = 0;
      bit seen_max = 0;
      chan_sel = 8'hBB; tx_ready = 1'b1; stream_valid = 1'b0;
      loop_a_valid = 1'b0; loop_b_valid = 1'b0;
      #1;
      chk("R6", "ready with no stream channel", {31'b0, stream_ready}, 32'd0);
      for (int n = 0; n < 70000; n++) begin
        @(negedge clk);
        if (!sample_valid || ch0_data !== model || ch1_data !== model) bad++;
        if (seen_max && model == 16'h0000) begin
          tx_ready = 1'b0;
          chk("R3", "wrap to zero", {16'b0, ch0_data}, 32'd0);
          model = model + 16'h1;
          break;
        end
        if (model == 16'hFFFF) begin
          seen_max = 1;
          chk("R3", "ramp top", {16'b0, ch1_data}, 32'h0000FFFF);
        end
        model = model + 16'h1;
      end
      chk("R3", "ramp mismatches", bad, 0);
      chk("R3", "wrap reached", {31'b0, seen_max}, 32'd1);
    end

    // R1 plain stream sample before arming
    chan_sel = 8'h22; stream_word = 32'h13572468; stream_valid = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    chk("R1", "ch0 pre-arm", {16'b0, ch0_data}, 32'h2468);
    tx_ready = 1'b0; sync_arm_set = 1'b1;
    @(negedge clk);
    chk("R7", "armed set", {31'b0, sync_armed}, 32'd1);
    chk("R9", "nosync not armed", {31'b0, ns_armed}, 32'd0);
    sync_arm_set = 1'b0; tx_ready = 1'b1; stream_valid = 1'b1; stream_word = 32'hCAFEF00D;
    #1;
    chk("R7", "ready while armed", {31'b0, stream_ready}, 32'd0);
    chk("R9", "nosync ready", {31'b0, ns_ready}, 32'd1);
    @(negedge clk);
    chk("R7", "valid while armed", {31'b0, sample_valid}, 32'd0);
    chk("R7", "ch0 zero while armed", {16'b0, ch0_data}, 32'd0);
    chk("R7", "ch1 zero while armed", {16'b0, ch1_data}, 32'd0);
    chk("R9", "nosync still issues", {16'b0, ns_ch0}, 32'hF00D);
    sync_in = 1'b1; stream2_valid = 1'b0;
    @(negedge clk);
    chk("R8", "stays armed without secondary valid", {31'b0, sync_armed}, 32'd1);
    chk("R8", "no peer start yet", {31'b0, peer_start}, 32'd0);
    stream2_valid = 1'b1;
    @(negedge clk);
    chk("R8", "armed self-clears", {31'b0, sync_armed}, 32'd0);
    chk("R8", "peer start pulse", {31'b0, peer_start}, 32'd1);
    chk("R7", "no sample on release edge", {31'b0, sample_valid}, 32'd0);
    sync_in = 1'b0; stream2_valid = 1'b0;
    #1;
    chk("R6", "ready after release", {31'b0, stream_ready}, 32'd1);
    @(negedge clk);
    chk("R8", "peer start one cycle", {31'b0, peer_start}, 32'd0);
    chk("R5", "first sample after start", {31'b0, sample_valid}, 32'd1);
    chk("R1", "ch0 after start", {16'b0, ch0_data}, 32'hF00D);
    chk("R1", "ch1 after start", {16'b0, ch1_data}, 32'hCAFE);

    tx_ready = 1'b0; stream_valid = 1'b0;
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule